// File: doc/BRIEF.md
# Sleep and Wake-up Sequencer

This block controls the power state of a small microcontroller. Software programs it through a small word-addressed register port. Writing a mode to the sleep word starts a sequence that takes the chip into hibernate or doze. During sleep the block drives enables that keep a chosen number of RAM pages, the logic state and the digital pads powered. Core power is removed only for the sleep period itself.

Each transition is a two-phase handshake with software. The sequencer raises a sync flag in the status word, and software clears that flag by writing 1 to it. On entry, power is cut only after the clear. On wake-up, the return to run mode completes only after a second clear. Wake-up comes from a counter running on a slow clock enable, from any of four external inputs, or from both. Each external input has its own enable, edge or level selection, polarity and interrupt enable.

The external inputs pass through a two-flop synchronizer before detection. Regulators, oscillators and power switches are outside the block and see only its enable outputs.

Top module: `slumber_ctrl`

## Requirements
- R1: The sleep word is at address 0, bits [7:0]. Writing it in run mode with bits [1:0] = 1 requests hibernate, and with bits [1:0] = 2 requests doze. Values 0 and 3 are stored but start no sequence. While asleep, `hib_active` or `doze_active` follows the stored mode.
- R2: While asleep, `ram_keep[p]` is 1 exactly for pages p <= sleep bits [5:4]. `state_keep` equals sleep bit 6 and `pad_keep` equals sleep bit 7. Outside sleep all of these outputs are 1. They stay stable for the whole sleep period.
- R3: Status is at address 3, and its bit 0 is the sync flag. Writing 1 to bit 0 clears the flag. Writing 0 leaves it unchanged.
- R4: One cycle after an accepted request, the sync flag reads 1 and `core_pwr_en` stays 1. The edge that clears the flag moves the block to sleep, so `core_pwr_en` is 0 from the next cycle.
- R5: On a wake request, `core_pwr_en` returns to 1 and the sync flag reads 1 in the same cycle. `run_mode` returns to 1 only after the edge that clears the flag.
- R6: The wake control word is at address 1, and its bit 0 enables the timer. The timeout is at address 2. The counter reads at address 4 and is zeroed on sleep entry. It advances by 1 on each `slow_tick` while asleep. The block wakes when the timer is enabled and the counter equals the timeout.
- R7: External input i is configured through the wake control word:
  - bit 4+i enables the input;
  - bit 8+i selects edge detection (1) or level detection (0);
  - bit 12+i selects the active polarity, high or rising (1) versus low or falling (0).

  An enabled detection seen while asleep starts wake-up.
- R8: Status bits [7:4] latch external events; detection runs in every state. Writing 1 to an event bit clears it, and a new event in the same cycle wins over the clear. `wake_irq` is the OR of the event bits whose interrupt enable (wake control bit 20+i) is set.
- R9: A write to the sleep word outside run mode is ignored, and the stored word is unchanged.
- R10: With no wake source enabled the block stays asleep until reset. Reset returns it to run mode.
- R11: Reads return zero-extended values; addresses 5 to 7 read 0. Reset clears every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| slow_tick | input | 1 | Slow sleep clock enable |
| ext_wake | input | 4 | Asynchronous external wake inputs |
| core_pwr_en | output | 1 | Core power enable, 0 only while asleep |
| hib_active | output | 1 | Asleep in hibernate |
| doze_active | output | 1 | Asleep in doze |
| ram_keep | output | 4 | Per-page RAM retention enables |
| state_keep | output | 1 | Logic state retention enable |
| pad_keep | output | 1 | Digital pad power enable |
| run_mode | output | 1 | Block is in run mode |
| wake_irq | output | 1 | External wake event interrupt |

## Verification
Two pairs of actions can land in the same clock cycle.

The first pair is a new external detection and a software write that clears that event bit. The bench holds a level-low input active and then writes 1 to its event bit. The bit must read 1 afterwards, and the interrupt must stay high.

The second pair is the sync clear that enters sleep and a wake request that is already pending. The bench enters sleep with an active level input, so the first sleep cycle must turn straight into a wake handshake.

A behavioural reference model, updated on every edge, judges every output on every cycle.

// File: rtl/slumber_ctrl.sv
module slumber_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        slow_tick,
  input  logic [3:0]  ext_wake,
  output logic        core_pwr_en,
  output logic        hib_active,
  output logic        doze_active,
  output logic [3:0]  ram_keep,
  output logic        state_keep,
  output logic        pad_keep,
  output logic        run_mode,
  output logic        wake_irq
);

  typedef enum logic [2:0] {S_RUN, S_PRE, S_HOFF, S_SLEEP, S_HON} st_t;

  st_t              st_q;
  logic [7:0]       sleep_q;
  logic [23:0]      wctl_q;
  logic [CNT_W-1:0] tmo_q, cnt_q;
  logic             sync_q;
  logic [3:0]       evt_q, sy1_q, sy2_q, prev_q;

  logic [3:0] en, edg, pol, ien, act, act_prev, hit;
  assign en  = wctl_q[7:4];
  assign edg = wctl_q[11:8];
  assign pol = wctl_q[15:12];
  assign ien = wctl_q[23:20];

  assign act      = ~(sy2_q ^ pol);
  assign act_prev = ~(prev_q ^ pol);
  assign hit      = en & ((edg & act & ~act_prev) | (~edg & act));

  logic wr_sleep, wr_stat, clr_sync, mode_ok, timer_hit, wake;
  assign wr_sleep  = reg_we && reg_addr == 3'd0;
  assign wr_stat   = reg_we && reg_addr == 3'd3;
  assign clr_sync  = wr_stat && reg_wdata[0];
  assign mode_ok   = reg_wdata[1:0] == 2'd1 || reg_wdata[1:0] == 2'd2;
  assign timer_hit = wctl_q[0] && cnt_q == tmo_q;
  assign wake      = timer_hit || (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_RUN;
      sleep_q <= '0;
      wctl_q  <= '0;
      tmo_q   <= '0;
      cnt_q   <= '0;
      sync_q  <= 1'b0;
      evt_q   <= '0;
      sy1_q   <= '0;
      sy2_q   <= '0;
      prev_q  <= '0;
    end else begin
      sy1_q  <= ext_wake;
      sy2_q  <= sy1_q;
      prev_q <= sy2_q;
      if (reg_we && reg_addr == 3'd1) wctl_q <= reg_wdata[23:0];
      if (reg_we && reg_addr == 3'd2) tmo_q  <= reg_wdata[CNT_W-1:0];
      evt_q <= (evt_q & ~(wr_stat ? reg_wdata[7:4] : 4'h0)) | hit;
      if (clr_sync) sync_q <= 1'b0;
      case (st_q)
        S_RUN: if (wr_sleep) begin
          sleep_q <= reg_wdata[7:0];
          if (mode_ok) st_q <= S_PRE;
        end
        S_PRE: begin
          sync_q <= 1'b1;
          st_q   <= S_HOFF;
        end
        S_HOFF: if (clr_sync) begin
          st_q  <= S_SLEEP;
          cnt_q <= '0;
        end
        S_SLEEP: if (wake) begin
          st_q   <= S_HON;
          sync_q <= 1'b1;
        end else if (slow_tick) begin
          cnt_q <= cnt_q + 1'b1;
        end
        S_HON: if (clr_sync) st_q <= S_RUN;
        default: st_q <= S_RUN;
      endcase
    end
  end

  logic asleep;
  assign asleep      = st_q == S_SLEEP;
  assign core_pwr_en = !asleep;
  assign run_mode    = st_q == S_RUN;
  assign hib_active  = asleep && sleep_q[1:0] == 2'd1;
  assign doze_active = asleep && sleep_q[1:0] == 2'd2;
  assign state_keep  = !asleep || sleep_q[6];
  assign pad_keep    = !asleep || sleep_q[7];
  assign wake_irq    = |(evt_q & ien);

  for (genvar p = 0; p < 4; p++) begin : g_page
    assign ram_keep[p] = !asleep || (2'(p) <= sleep_q[5:4]);
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {24'h0, sleep_q};
      3'd1:    reg_rdata = {8'h0, wctl_q};
      3'd2:    reg_rdata = 32'(tmo_q);
      3'd3:    reg_rdata = {24'h0, evt_q, 3'b000, sync_q};
      3'd4:    reg_rdata = 32'(cnt_q);
      default: reg_rdata = 32'h0;
    endcase
  end

  a_r2_keep_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_pwr_en && $past(!core_pwr_en)) |-> $stable({ram_keep, state_keep, pad_keep}));
  a_r3_write0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !reg_wdata[0] && sync_q) |=> sync_q);
  a_r4_sync_before_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_pwr_en) |-> $past(sync_q));
  a_r5_wake_raises_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pwr_en) |-> sync_q);
  a_r6_count_zero_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_pwr_en) |-> cnt_q == '0);
  a_r9_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_RUN && wr_sleep) |=> $stable(sleep_q));

endmodule

// File: tb/slumber_ctrl_tb_top.sv
`timescale 1ns/100ps
module slumber_ctrl_tb_top;
  logic clk = 0, rst_n = 0, reg_we = 0, slow_tick = 0;
  logic [2:0] reg_addr = 3'd3;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [3:0] ext_wake = 0, ram_keep;
  logic core_pwr_en, hib_active, doze_active, state_keep, pad_keep, run_mode, wake_irq;
  int n_chk = 0, n_fail = 0, tcnt = 0;
  bit tick_en = 0;

  always #2.5 clk = ~clk;

  slumber_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slow_tick(slow_tick), .ext_wake(ext_wake),
    .core_pwr_en(core_pwr_en), .hib_active(hib_active), .doze_active(doze_active),
    .ram_keep(ram_keep), .state_keep(state_keep), .pad_keep(pad_keep),
    .run_mode(run_mode), .wake_irq(wake_irq));

  // behavioural reference: 0 run, 1 pre-sleep, 2 wait clear, 3 asleep, 4 wait clear on wake
  int m_st;
  bit [7:0] m_sleep;
  bit [23:0] m_wctl;
  bit [31:0] m_tmo, m_cnt;
  bit m_sync;
  bit [3:0] m_evt, m_s1, m_s2, m_prev, m_hit;
  bit m_wake, m_clr, a_now, a_old;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_sleep = 0; m_wctl = 0; m_tmo = 0; m_cnt = 0; m_sync = 0;
      m_evt = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        a_now = m_wctl[12+i] ? m_s2[i] : !m_s2[i];
        a_old = m_wctl[12+i] ? m_prev[i] : !m_prev[i];
        m_hit[i] = m_wctl[4+i] && (m_wctl[8+i] ? (a_now && !a_old) : a_now);
      end
      m_wake = (m_wctl[0] && m_cnt == m_tmo) || m_hit != 0;
      m_clr = reg_we && reg_addr == 3 && reg_wdata[0];
      if (reg_we && reg_addr == 3) m_evt = m_evt & ~reg_wdata[7:4];
      m_evt = m_evt | m_hit;
      if (m_clr) m_sync = 0;
      case (m_st)
        0: if (reg_we && reg_addr == 0) begin
             m_sleep = reg_wdata[7:0];
             if (reg_wdata[1:0] == 1 || reg_wdata[1:0] == 2) m_st = 1;
           end
        1: begin m_sync = 1; m_st = 2; end
        2: if (m_clr) begin m_st = 3; m_cnt = 0; end
        3: if (m_wake) begin m_st = 4; m_sync = 1; end
           else if (slow_tick) m_cnt = m_cnt + 1;
        4: if (m_clr) m_st = 0;
        default: m_st = 0;
      endcase
      if (reg_we && reg_addr == 1) m_wctl = reg_wdata[23:0];
      if (reg_we && reg_addr == 2) m_tmo = reg_wdata;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_wake;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    tcnt++;
    slow_tick = tick_en && (tcnt % 3 == 0);
    #1;
    begin
      bit sl;
      logic [31:0] er;
      string rt;
      sl = (m_st == 3);
      case (reg_addr)
        0: begin er = {24'h0, m_sleep}; rt = "R1 sleep word"; end
        1: begin er = {8'h0, m_wctl}; rt = "R7 wake ctl"; end
        2: begin er = m_tmo; rt = "R6 timeout"; end
        3: begin er = {24'h0, m_evt, 3'b0, m_sync}; rt = "R3 status"; end
        4: begin er = m_cnt; rt = "R6 counter"; end
        default: begin er = 0; rt = "R11 unused"; end
      endcase
      chk(rt, reg_rdata, er);
      chk("R4 core power", core_pwr_en, !sl);
      chk("R1 hibernate", hib_active, sl && m_sleep[1:0] == 1);
      chk("R1 doze", doze_active, sl && m_sleep[1:0] == 2);
      for (int p = 0; p < 4; p++) chk("R2 ram keep", ram_keep[p], !sl || p <= m_sleep[5:4]);
      chk("R2 state keep", state_keep, !sl || m_sleep[6]);
      chk("R2 pad keep", pad_keep, !sl || m_sleep[7]);
      chk("R5 run mode", run_mode, m_st == 0);
      chk("R8 wake irq", wake_irq, (m_evt & m_wctl[23:20]) != 0);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_addr = 3; reg_wdata = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pwr();
    for (int n = 0; n < 500 && !core_pwr_en; n++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1;
    idle(1); #1; chk("R11 reset status", reg_rdata, 0);
    // R1: mode 0 stored but ignored
    wr(0, 32'h70); #1; chk("R1 mode0 no sequence", run_mode, 1);
    // timer hibernate, all retained (R6, R2, R3, R4, R9, R5)
    wr(2, 5); wr(1, 1); tick_en = 1; wr(0, 32'hF1);
    idle(3); wr(3, 0); #1; chk("R3 write0 keeps sync", reg_rdata[0], 1);
    chk("R4 power held", core_pwr_en, 1);
    wr(3, 1); #1; chk("R4 asleep after clear", core_pwr_en, 0);
    wr(0, 32'h02); reg_addr = 0; #1; chk("R9 word kept", reg_rdata, 32'hF1);
    reg_addr = 4; wait_pwr(); reg_addr = 3; #1;
    chk("R6 timer wake", core_pwr_en, 1); chk("R5 not yet run", run_mode, 0);
    wr(3, 1); #1; chk("R5 run after clear", run_mode, 1);
    // external rising edge on input 0, doze with two pages
    wr(1, (1 << 4) | (1 << 8) | (1 << 12) | (1 << 20)); wr(0, 32'h12);
    idle(2); wr(3, 1); idle(5); ext_wake[0] = 1; wait_pwr(); #1;
    chk("R7 edge wake", core_pwr_en, 1); chk("R8 irq", wake_irq, 1);
    wr(3, 1); wr(3, 32'h10); ext_wake[0] = 0;
    // level-low on input 2: set beats clear, and immediate wake at entry
    ext_wake[2] = 0; wr(1, (1 << 6) | (1 << 22)); idle(4);
    wr(3, 32'h40); #1; chk("R8 set wins over clear", reg_rdata[6], 1);
    wr(0, 32'h21); idle(2); wr(3, 1); idle(1); wait_pwr(); #1;
    chk("R7 level wake", core_pwr_en, 1);
    wr(3, 1);
    // no wake source
    ext_wake[2] = 1; wr(1, 0); wr(3, 32'hF0); wr(0, 32'h01); idle(2); wr(3, 1);
    idle(60); #1; chk("R10 stays asleep", core_pwr_en, 0);
    @(negedge clk); rst_n = 0; idle(2); rst_n = 1; #1;
    chk("R10 reset wakes", run_mode, 1);
    idle(3);
    finish_run();
  end
endmodule